// File: doc/BRIEF.md
# Cascaded Interrupt Group Register Bank

This block holds the register state of one interrupt group. Up to 32 event lines arrive from sources inside the chip; each one that is not masked is latched as a pending bit. Software reaches four 32-bit registers through a simple word-addressed read/write port:

- a read-only status view of the live event lines;
- a mask that blocks events from being latched;
- the pending (identity) register, where writing 1 clears a bit;
- an enable register that chooses which pending bits are reported upward.

The group drives a registered summary vector, pending AND enable, to the next level of the interrupt tree. A group that sits above another group can also take cascaded set requests from it. These pass through the same mask as local events.

A masked event is thrown away and is not remembered. Clearing the mask later does not bring it back. When a set and a clear reach the same pending bit in the same cycle, the set wins, so an event is never lost against a software acknowledge.

Top module: `irq_group_bank`

## Requirements
- R1: After reset the mask, pending and enable registers all read 0 and `sumOut` is 0.
- R2: A read at offset 0x0 returns the current value of `evtIn` in the same cycle. A write to offset 0x0 changes no register.
- R3: An event on bit b with mask bit b equal to 0 makes pending bit b read 1 from the clock edge that samples the event.
- R4: An event on a masked bit is discarded. Clearing the mask bit later does not set the pending bit.
- R5: A write at offset 0x8 clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R6: If a pending bit is set by an event or cascade request at the same edge as a write-1-to-clear of that bit, the bit ends up set.
- R7: A write at offset 0x4 (mask) or 0xC (enable) replaces the whole register, and the new value reads back.
- R8: After every clock edge, `sumOut` equals pending AND enable as they stand after that edge. This includes edges with enable writes, clears and event arrivals.
- R9: Each asserted bit of `cascIn` is ORed into the pending register only where the mask bit is 0. Deasserted cascade bits never clear pending bits.
- R10: An offset with either of its two low bits set reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| evtIn | input | 32 | Event lines, one per bit, sampled every cycle |
| cascIn | input | 32 | Set requests from a lower-level group |
| regAddr | input | 4 | Byte offset of the register accessed |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register, combinational |
| sumOut | output | 32 | Registered pending AND enable, sent to the level above |

## Verification
The bench aims at the following corner cases:

- **Masked events.** It fires an event on a masked bit and then clears the mask. A design that holds masked events for later would report that bit as pending.
- **Set against clear.** It acknowledges a bit in the same cycle the event fires again. A design that lets the clear win would lose the second event.
- **Cascade mask and idle lines.** It drives cascade requests through a partial mask and then releases them. A design that copied the cascade lines into the pending register, rather than ORing them in, would either latch the masked cascade bit or drop bits once the lines fall.
- **Ignored addresses.** It writes to the status offset and to a misaligned offset. A loose address decoder would corrupt the mask.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  // Byte offsets from the group base; software depends on these.
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_MASK   = 4;
  localparam int unsigned OFS_IDENT  = 8;
  localparam int unsigned OFS_ENABLE = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_IDENT,
    SEL_ENABLE
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrIdent;
    logic   wrEnable;
    rdSel_e rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/irqg_ctrl.sv
module irqg_ctrl
  import irqg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrb_t         strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    case (regAddr)
      ADDR_W'(OFS_STATUS): strb.rdSel = SEL_STATUS;
      ADDR_W'(OFS_MASK): begin
        strb.rdSel  = SEL_MASK;
        strb.wrMask = regWrEn;
      end
      ADDR_W'(OFS_IDENT): begin
        strb.rdSel   = SEL_IDENT;
        strb.wrIdent = regWrEn;
      end
      ADDR_W'(OFS_ENABLE): begin
        strb.rdSel    = SEL_ENABLE;
        strb.wrEnable = regWrEn;
      end
      default: strb.rdSel = SEL_NONE;
    endcase
  end

  // R7 / R10: at most one register is written per access.
  p_one_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMask, strb.wrIdent, strb.wrEnable}));

  // R10: misaligned offsets produce no write strobe.
  p_misaligned_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[1:0] != 2'b00) |-> !(strb.wrMask || strb.wrIdent || strb.wrEnable));

endmodule

// File: rtl/irqg_datapath.sv
module irqg_datapath
  import irqg_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter bit          HAS_CASCADE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] evtIn,
  input  logic [WIDTH-1:0] cascIn,
  input  logic [WIDTH-1:0] wrData,
  input  ctrlStrb_t        strb,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] sumOut
);

  logic [WIDTH-1:0] maskQ, identQ, enQ, sumQ;
  logic [WIDTH-1:0] cascVec, setVec, clrVec, identD, enD, maskD;

  generate
    if (HAS_CASCADE) begin : g_casc
      assign cascVec = cascIn;
    end else begin : g_nocasc
      assign cascVec = '0;
    end
  endgenerate

  // Set requests pass the mask that holds before this edge.
  assign setVec = (evtIn | cascVec) & ~maskQ;
  assign clrVec = strb.wrIdent ? wrData : '0;
  // Set is applied after clear, so it wins on a collision.
  assign identD = (identQ & ~clrVec) | setVec;
  assign enD    = strb.wrEnable ? wrData : enQ;
  assign maskD  = strb.wrMask   ? wrData : maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      identQ <= '0;
      enQ    <= '0;
      sumQ   <= '0;
    end else begin
      maskQ  <= maskD;
      identQ <= identD;
      enQ    <= enD;
      sumQ   <= identD & enD;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STATUS: rdData = evtIn;
      SEL_MASK:   rdData = maskQ;
      SEL_IDENT:  rdData = identQ;
      SEL_ENABLE: rdData = enQ;
      default:    rdData = '0;
    endcase
  end

  assign sumOut = sumQ;

  // R3: an unmasked event is pending after the edge that sampled it.
  p_unmasked_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(evtIn) & ~$past(maskQ)) & ~identQ) == '0));

  // R4: a bit that becomes pending was unmasked when it was set.
  p_masked_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((identQ & ~$past(identQ) & $past(maskQ)) == '0));

  // R5: bits written as 1 are gone unless a request set them again.
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIdent |=> ((identQ & $past(wrData) & ~$past(evtIn | cascVec)) == '0));

  // R9: pending bits are lost only through a software clear.
  p_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(identQ) & ~$past(clrVec) & ~identQ) == '0));

  // R8: the registered summary tracks pending AND enable.
  p_summary_r8: assert property (@(posedge clk) disable iff (!rstN)
    sumQ == (identQ & enQ));

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
  import irqg_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter bit          HAS_CASCADE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  evtIn,
  input  logic [WIDTH-1:0]  cascIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  output logic [WIDTH-1:0]  sumOut
);

  ctrlStrb_t strb;

  irqg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  irqg_datapath #(.WIDTH(WIDTH), .HAS_CASCADE(HAS_CASCADE)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .evtIn  (evtIn),
    .cascIn (cascIn),
    .wrData (regWrData),
    .strb   (strb),
    .rdData (regRdData),
    .sumOut (sumOut)
  );

endmodule

// File: tb/irq_group_bank_tb_top.sv
module irq_group_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0, cascIn = '0, regWrData = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regRdData, sumOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Behavioural reference state.
  logic [31:0] mMask = '0, mId = '0, mEn = '0;

  always #10 clk = ~clk;

  irq_group_bank dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .cascIn(cascIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sumOut(sumOut)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [3:0] a, input logic [31:0] e);
    case (a)
      4'h0: return e;
      4'h4: return mMask;
      4'h8: return mId;
      4'hC: return mEn;
      default: return 32'h0;
    endcase
  endfunction

  // One clock: drive at negedge, check read before the edge, update model
  // at the edge, check the summary after the edge.
  task automatic cyc(input logic [31:0] e, input logic [31:0] c, input logic we,
                     input logic [3:0] a, input logic [31:0] d, input string rq);
    logic [31:0] setV, nId;
    evtIn = e; cascIn = c; regWrEn = we; regAddr = a; regWrData = d;
    #1;
    chk(rq, regRdData, modelRead(a, e));
    @(posedge clk);
    setV = (e | c) & ~mMask;
    nId  = (mId & ~((we && a == 4'h8) ? d : 32'h0)) | setV;
    if (we && a == 4'h4) mMask = d;
    if (we && a == 4'hC) mEn = d;
    mId = nId;
    @(negedge clk);
    chk("R8", sumOut, mId & mEn);
  endtask

  task automatic rd(input logic [3:0] a, input string rq);
    cyc(32'h0, 32'h0, 1'b0, a, 32'h0, rq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", sumOut, 32'h0);
    rstN = 1'b1;
    rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");

    // R7: whole-register enable write and readback
    cyc(0, 0, 1, 4'hC, 32'hFFFF_FFFF, "R7");
    rd(4'hC, "R7");

    // R3: engine event bits 0,4,8 then 16,20,24
    cyc(32'h0000_0111, 0, 0, 4'h0, 0, "R2");
    rd(4'h8, "R3");
    cyc(32'h0111_0000, 0, 0, 4'h8, 0, "R3");
    rd(4'h8, "R3");

    // R4: masked event dropped, unmasking does not reveal it
    cyc(0, 0, 1, 4'h8, 32'hFFFF_FFFF, "R5");
    cyc(0, 0, 1, 4'h4, 32'h0001_0000, "R7");
    rd(4'h4, "R7");
    cyc(32'h0011_0000, 0, 0, 4'h8, 0, "R4");
    cyc(0, 0, 1, 4'h4, 32'h0, "R4");
    rd(4'h8, "R4");

    // R5: write-1-to-clear on a subset
    cyc(32'h0000_0111, 0, 0, 4'h8, 0, "R3");
    cyc(0, 0, 1, 4'h8, 32'h0000_0011, "R5");
    rd(4'h8, "R5");

    // R6: set beats clear in the same cycle
    cyc(32'h0000_0100, 0, 1, 4'h8, 32'h0000_0100, "R6");
    rd(4'h8, "R6");

    // R9: cascade bits 17,19,21-23 through mask on bit 19
    cyc(0, 0, 1, 4'h8, 32'hFFFF_FFFF, "R5");
    cyc(0, 0, 1, 4'h4, 32'h0008_0000, "R9");
    cyc(0, 32'h00EA_0000, 0, 4'h8, 0, "R9");
    cyc(0, 32'h0, 0, 4'h8, 0, "R9");
    rd(4'h8, "R9");

    // R8: partial enable reflects into the summary
    cyc(0, 0, 1, 4'hC, 32'h0022_0000, "R8");
    cyc(0, 0, 1, 4'h8, 32'h0002_0000, "R8");
    cyc(32'h0000_0001, 0, 1, 4'hC, 32'h0000_0001, "R8");

    // R2: status is the live event value; writes to it are ignored
    cyc(32'hA5A5_0000, 0, 1, 4'h0, 32'hFFFF_FFFF, "R2");
    rd(4'h4, "R2"); rd(4'hC, "R2");

    // R10: misaligned offsets read 0 and ignore writes
    cyc(0, 0, 1, 4'h5, 32'hFFFF_FFFF, "R10");
    cyc(0, 0, 1, 4'hA, 32'hFFFF_FFFF, "R10");
    rd(4'h5, "R10");
    rd(4'h4, "R10"); rd(4'h8, "R10"); rd(4'hC, "R10");

    // Background: mixed traffic compared every clock
    for (int i = 0; i < 40; i++) begin
      cyc(32'h1 << (i % 32), (i % 3 == 0) ? 32'h0028_0000 : 32'h0,
          (i % 5 == 0), 4'(((i % 4)) * 4), 32'h9 * i, "R8");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule